// File: doc/BRIEF.md
# GPIO Pin Event Detector with Wake Status

This unit watches the filtered input levels of a banked group of GPIO pins and turns them into sticky per-pin event flags. Each pin is programmed on its own either for edge detection, with separate enables for low-to-high and high-to-low transitions, or for level detection with a selectable active-low polarity. Pending flags are cleared by write-one-to-clear strobes. Pins that software has enabled are combined into a single registered interrupt line that covers every bank.

A second, independent status path records wake events. A pin sets its wake flag only while its wake enable is set. Wake flags have their own write-one-to-clear strobe. The enabled wake flags drive a registered wake request line.

The register bus that produces the configuration vectors and clear strobes lies outside this unit, and so does the pin output path.

Top module: `gpio_evt_unit`

## Requirements
- R1: While reset is high, every source flag, every wake flag, `irq_o` and `wake_o` read 0.
- R2: When a pin's mode bit is 0 (edge mode), a 0-to-1 change of its level sets its source flag if its rise enable is 1, and a 1-to-0 change sets the flag if its fall enable is 1. Both enables may be set together. A set flag holds until it is cleared.
- R3: When a pin's mode bit is 1 (level mode), the pin is active when its level differs from its polarity bit (polarity 1 means active low). The source flag is set again on every clock while the pin stays active, so a clear takes effect only once the pin is inactive.
- R4: A 1 in `src_clr` bit i clears source flag i on the next clock, unless that clock also sees an event on pin i. Zero bits leave their flags unchanged.
- R5: `irq_o` is 1 exactly one clock after any bank holds a pin whose source flag and interrupt enable are both 1, and 0 one clock after no such pin exists.
- R6: No edge event is reported on the first clock after reset is released, even when a pin is high during reset and its rise enable is set.
- R7: An event on pin i sets wake flag i only if wake enable bit i is 1. `wake_clr` clears wake flags the way `src_clr` clears source flags. Neither strobe affects the other status vector.
- R8: `wake_o` is 1 exactly one clock after any pin has both its wake flag and its wake enable set.
- R9: Changing polarity bits while a pin is in edge mode produces no event, so writing polarity before mode raises no spurious level event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_lvl | input | BANKS*BANK_W | Filtered pin levels |
| rise_en | input | BANKS*BANK_W | Rising-edge enable per pin |
| fall_en | input | BANKS*BANK_W | Falling-edge enable per pin |
| lvl_mode | input | BANKS*BANK_W | 1 = level detection, 0 = edge detection |
| act_low | input | BANKS*BANK_W | Level polarity, 1 = active low |
| irq_en | input | BANKS*BANK_W | Interrupt enable per pin |
| wake_en | input | BANKS*BANK_W | Wake enable per pin |
| src_clr | input | BANKS*BANK_W | Write-one-to-clear strobe for source flags |
| wake_clr | input | BANKS*BANK_W | Write-one-to-clear strobe for wake flags |
| src_stat | output | BANKS*BANK_W | Source flags |
| wake_stat | output | BANKS*BANK_W | Wake flags |
| irq_o | output | 1 | Combined registered interrupt |
| wake_o | output | 1 | Registered wake request |

## Verification
The bench walks every pin through every combination of rise and fall enables, and through level mode with both polarities. A design that swaps the rise and fall enables, or that leaks an event onto a neighbouring pin, shows the wrong flag pattern.

It holds every pin high with rise enabled across reset. A design without a start-up guard then raises a false rising edge on all pins.

In level mode it asserts a clear while the pin is still active. A design that lets the clear win drops the flag that R3 keeps.

It flips polarity bits in edge mode to catch a detector that looks at polarity outside level mode. It also checks that clearing source flags leaves wake flags alone, and the reverse, and that enables in the upper bank reach `irq_o`.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

  typedef enum logic {
    DET_EDGE  = 1'b0,
    DET_LEVEL = 1'b1
  } det_mode_e;

  // true when a level-mode pin sits at its active level
  function automatic logic lvl_is_active(input logic lvl, input logic low_active);
    return lvl ^ low_active;
  endfunction

  // next value of a write-one-to-clear sticky flag; a new event beats a clear
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
  import gpio_evt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] rise_en,
  input  logic [W-1:0] fall_en,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] act_low,
  output logic [W-1:0] evt
);

  logic [W-1:0] prev_q;
  logic         armed_q;
  logic [W-1:0] edge_evt;
  logic [W-1:0] level_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= lvl;
      armed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic went_up, went_down;
    assign went_up      = lvl[i] & ~prev_q[i];
    assign went_down    = ~lvl[i] & prev_q[i];
    assign edge_evt[i]  = armed_q & ((went_up & rise_en[i]) | (went_down & fall_en[i]));
    assign level_evt[i] = lvl_is_active(lvl[i], act_low[i]);
    always_comb begin
      case (det_mode_e'(mode[i]))
        DET_LEVEL: evt[i] = level_evt[i];
        default:   evt[i] = edge_evt[i];
      endcase
    end
  end

  a_r6_no_edge_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (edge_evt == '0));

endmodule

// File: rtl/gpio_evt_status.sv
module gpio_evt_status
  import gpio_evt_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat_q
);

  logic [W-1:0] stat_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign stat_d[i] = sticky_next(stat_q[i], set[i], clr[i]);

    a_r4_clear_takes: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set[i]) |=> !stat_q[i]);
    a_r2_flag_holds: assert property (@(posedge clk) disable iff (rst)
      (stat_q[i] && !clr[i]) |=> stat_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

endmodule

// File: rtl/gpio_evt_reduce.sv
module gpio_evt_reduce #(
  parameter int BANKS  = 2,
  parameter int BANK_W = 8,
  localparam int N     = BANKS * BANK_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] stat,
  input  logic [N-1:0] en,
  output logic         any_q
);

  logic [BANKS-1:0] bank_hit;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_hit[b] = |(stat[b*BANK_W +: BANK_W] & en[b*BANK_W +: BANK_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) any_q <= 1'b0;
    else     any_q <= |bank_hit;
  end

  a_r5_rise_follows: assert property (@(posedge clk) disable iff (rst)
    (|(stat & en)) |=> any_q);
  a_r5_fall_follows: assert property (@(posedge clk) disable iff (rst)
    !(|(stat & en)) |=> !any_q);

endmodule

// File: rtl/gpio_evt_unit.sv
module gpio_evt_unit #(
  parameter int BANKS  = 2,
  parameter int BANK_W = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BANKS*BANK_W-1:0]   pin_lvl,
  input  logic [BANKS*BANK_W-1:0]   rise_en,
  input  logic [BANKS*BANK_W-1:0]   fall_en,
  input  logic [BANKS*BANK_W-1:0]   lvl_mode,
  input  logic [BANKS*BANK_W-1:0]   act_low,
  input  logic [BANKS*BANK_W-1:0]   irq_en,
  input  logic [BANKS*BANK_W-1:0]   wake_en,
  input  logic [BANKS*BANK_W-1:0]   src_clr,
  input  logic [BANKS*BANK_W-1:0]   wake_clr,
  output logic [BANKS*BANK_W-1:0]   src_stat,
  output logic [BANKS*BANK_W-1:0]   wake_stat,
  output logic                      irq_o,
  output logic                      wake_o
);

  localparam int N = BANKS * BANK_W;

  logic [N-1:0] evt;
  logic [N-1:0] wake_set;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    localparam int LO = b * BANK_W;

    gpio_evt_detect #(.W(BANK_W)) u_det (
      .clk     (clk),
      .rst     (rst),
      .lvl     (pin_lvl [LO +: BANK_W]),
      .rise_en (rise_en [LO +: BANK_W]),
      .fall_en (fall_en [LO +: BANK_W]),
      .mode    (lvl_mode[LO +: BANK_W]),
      .act_low (act_low [LO +: BANK_W]),
      .evt     (evt     [LO +: BANK_W])
    );

    gpio_evt_status #(.W(BANK_W)) u_src (
      .clk    (clk),
      .rst    (rst),
      .set    (evt     [LO +: BANK_W]),
      .clr    (src_clr [LO +: BANK_W]),
      .stat_q (src_stat[LO +: BANK_W])
    );

    gpio_evt_status #(.W(BANK_W)) u_wake (
      .clk    (clk),
      .rst    (rst),
      .set    (wake_set [LO +: BANK_W]),
      .clr    (wake_clr [LO +: BANK_W]),
      .stat_q (wake_stat[LO +: BANK_W])
    );
  end

  assign wake_set = evt & wake_en;

  gpio_evt_reduce #(.BANKS(BANKS), .BANK_W(BANK_W)) u_irq_or (
    .clk   (clk),
    .rst   (rst),
    .stat  (src_stat),
    .en    (irq_en),
    .any_q (irq_o)
  );

  gpio_evt_reduce #(.BANKS(BANKS), .BANK_W(BANK_W)) u_wake_or (
    .clk   (clk),
    .rst   (rst),
    .stat  (wake_stat),
    .en    (wake_en),
    .any_q (wake_o)
  );

  for (genvar i = 0; i < N; i++) begin : g_chk
    a_r3_level_refires: assert property (@(posedge clk) disable iff (rst)
      (lvl_mode[i] && (pin_lvl[i] ^ act_low[i])) |=> src_stat[i]);
    a_r7_wake_gated: assert property (@(posedge clk) disable iff (rst)
      (!wake_en[i] && !wake_stat[i]) |=> !wake_stat[i]);
    a_r9_edge_ignores_polarity: assert property (@(posedge clk) disable iff (rst)
      (!lvl_mode[i] && $stable(pin_lvl[i]) && !src_stat[i]) |=> !src_stat[i]);
  end

endmodule

// File: tb/gpio_evt_unit_tb.sv
module gpio_evt_unit_tb;

  localparam int BANKS  = 2;
  localparam int BANK_W = 8;
  localparam int N      = BANKS * BANK_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] pin_lvl = '0, rise_en = '0, fall_en = '0, lvl_mode = '0, act_low = '0;
  logic [N-1:0] irq_en = '0, wake_en = '0, src_clr = '0, wake_clr = '0;
  logic [N-1:0] src_stat, wake_stat;
  logic irq_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  gpio_evt_unit #(.BANKS(BANKS), .BANK_W(BANK_W)) u_dut (
    .clk(clk), .rst(rst), .pin_lvl(pin_lvl), .rise_en(rise_en), .fall_en(fall_en),
    .lvl_mode(lvl_mode), .act_low(act_low), .irq_en(irq_en), .wake_en(wake_en),
    .src_clr(src_clr), .wake_clr(wake_clr), .src_stat(src_stat), .wake_stat(wake_stat),
    .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic cyc(input int k = 1);
    for (int j = 0; j < k; j++) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_all();
    src_clr = '1; wake_clr = '1;
    cyc();
    src_clr = '0; wake_clr = '0;
  endtask

  initial begin
    // R1: reset state with pins high and rise enabled
    pin_lvl = '1; rise_en = '1; irq_en = '1; wake_en = '1;
    cyc(3);
    chk("R1 src", src_stat, '0);
    chk("R1 wake", wake_stat, '0);
    chk("R1 irq", N'(irq_o), '0);
    chk("R1 wake_o", N'(wake_o), '0);
    // R6: no false edge after reset release
    rst = 1'b0;
    cyc();
    chk("R6 first cycle", src_stat, '0);
    cyc(2);
    chk("R6 later", src_stat, '0);
    pin_lvl = '0; irq_en = '0; wake_en = '0;
    cyc(2);
    clear_all();
    cyc();

    // R2: edge sweep over every pin and enable combination
    for (int p = 0; p < N; p++) begin
      for (int rf = 0; rf < 4; rf++) begin
        rise_en = rf[0] ? '1 : '0;
        fall_en = rf[1] ? '1 : '0;
        pin_lvl = N'(1) << p;
        cyc();
        chk("R2 rise", src_stat, rf[0] ? (N'(1) << p) : '0);
        cyc();
        chk("R2 held", src_stat, rf[0] ? (N'(1) << p) : '0);
        clear_all();
        pin_lvl = '0;
        cyc();
        chk("R2 fall", src_stat, rf[1] ? (N'(1) << p) : '0);
        clear_all();
      end
    end
    rise_en = '0; fall_en = '0;

    // R3: level sweep, both polarities
    for (int pol = 0; pol < 2; pol++) begin
      act_low = pol[0] ? '1 : '0;
      pin_lvl = pol[0] ? '1 : '0;
      cyc();
      lvl_mode = '1;
      cyc();
      clear_all();
      cyc();
      chk("R3 idle", src_stat, '0);
      for (int p = 0; p < N; p++) begin
        pin_lvl[p] = ~pin_lvl[p];
        cyc();
        chk("R3 active", src_stat, N'(1) << p);
        src_clr = '1;
        cyc();
        src_clr = '0;
        chk("R3 clear while active", src_stat, N'(1) << p);
        pin_lvl[p] = ~pin_lvl[p];
        cyc();
        chk("R3 sticky", src_stat, N'(1) << p);
        clear_all();
        chk("R3 cleared", src_stat, '0);
      end
      lvl_mode = '0;
      cyc();
    end
    act_low = '0; pin_lvl = '0;
    cyc(2);
    clear_all();

    // R9: polarity change in edge mode raises nothing
    rise_en = '1; fall_en = '1;
    cyc();
    act_low = '1;
    cyc();
    chk("R9 polarity in edge mode", src_stat, '0);
    cyc();
    chk("R9 still quiet", src_stat, '0);
    lvl_mode = '1;
    cyc();
    chk("R3 active low after type", src_stat, '1);
    lvl_mode = '0; act_low = '0;
    cyc();
    clear_all();
    chk("R9 back to idle", src_stat, '0);

    // R4: zero bits of the clear leave flags alone
    rise_en = '1; fall_en = '0;
    pin_lvl = (N'(1) << 1) | (N'(1) << 14);
    cyc();
    src_clr = N'(1) << 1;
    cyc();
    src_clr = '0;
    chk("R4 partial clear", src_stat, N'(1) << 14);
    src_clr = N'(1) << 3;
    cyc();
    src_clr = '0;
    chk("R4 zero-bit clear", src_stat, N'(1) << 14);

    // R5: combined interrupt across banks
    irq_en = N'(1) << 5;
    cyc(2);
    chk("R5 unmatched enable", N'(irq_o), '0);
    irq_en = N'(1) << 14;
    cyc();
    chk("R5 upper bank", N'(irq_o), N'(1));
    irq_en = '0;
    cyc();
    chk("R5 masked", N'(irq_o), '0);
    irq_en = '1;
    cyc();
    chk("R5 re-enabled", N'(irq_o), N'(1));
    clear_all();
    chk("R5 lag after clear", N'(irq_o), N'(1));
    cyc();
    chk("R5 dropped", N'(irq_o), '0);
    pin_lvl = '0; irq_en = '0;
    cyc();

    // R7 / R8: wake path
    wake_en = N'(1) << 2;
    pin_lvl = (N'(1) << 2) | (N'(1) << 9);
    cyc();
    chk("R7 wake gated", wake_stat, N'(1) << 2);
    chk("R7 src both", src_stat, (N'(1) << 2) | (N'(1) << 9));
    cyc();
    chk("R8 wake_o", N'(wake_o), N'(1));
    src_clr = '1;
    cyc();
    src_clr = '0;
    chk("R7 src clear spares wake", wake_stat, N'(1) << 2);
    chk("R7 src cleared", src_stat, '0);
    wake_clr = N'(1) << 9;
    cyc();
    wake_clr = '0;
    chk("R7 wake zero-bit", wake_stat, N'(1) << 2);
    wake_en = '0;
    cyc();
    chk("R8 wake_o masked", N'(wake_o), '0);
    chk("R7 flag kept", wake_stat, N'(1) << 2);
    wake_clr = N'(1) << 2;
    cyc();
    wake_clr = '0;
    chk("R7 wake cleared", wake_stat, '0);
    wake_en = '1;
    cyc();
    chk("R8 wake_o idle", N'(wake_o), '0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule